// File: doc/BRIEF.md
# Four-Lane Parallel-Offset Fixed String Matcher

The block scans a byte stream that arrives four characters per clock and flags every place where one fixed four-character string appears, whatever the alignment of that string against the word boundaries. It holds the last three characters of the previous accepted word. Together with the current word, these form a seven-character view. Four candidate start positions inside that view are tested in the same cycle.

The string is a build-time parameter. Each of its characters is held once and drives one comparator per start position. A start position is a hit only when all four of its comparators agree. The block reports a hit when any start position is a hit, along with the index of the earliest position that hit. A start-of-packet strobe and reset both discard the held characters, so a match can never join bytes from two different packets.

The block sits in a payload inspection path as a cheap prefilter. It keeps pace with a 32-bit stream at one word per clock and needs no memory lookup.

Top module: `quad_lane_matcher`

## Requirements
- R1: When in_valid is high, the four characters of in_word are consumed, with lane 0 (bits 7:0) as the earliest character. hit and hit_offset are registered and reflect that word one clock later. After a cycle with in_valid low, hit is low.
- R2: The pattern parameter holds its first character in bits 7:0. A pattern that lies entirely in lanes 0 to 3 of one word is reported with hit_offset 3.
- R3: A pattern that starts in the previous accepted word and ends in lane k (k = 0, 1 or 2) of the current word is reported with hit_offset k. The offset index is the start position in the seven-character view, where positions 0 to 2 are lanes 1 to 3 of the previous word.
- R4: With pattern "ABCD", a previous word holding C, A, B in lanes 1 to 3, followed by the word C, D, F, E, gives a hit at hit_offset 1.
- R5: After reset, the held characters are invalid. The first word accepted after reset can only hit at offset 3.
- R6: A word accepted with in_sop high ignores the held characters and can only hit at offset 3. Later words again use the held characters.
- R7: Cycles with in_valid low neither advance nor clear the held characters. A pattern split around idle cycles is still found.
- R8: When several offsets hit in one word, hit is high and hit_offset is the lowest of them.
- R9: During and right after reset, hit is 0 and hit_offset is 0. hit_offset is 0 whenever hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_word carries four stream characters this cycle |
| in_sop | input | 1 | This word begins a new packet; held characters are discarded |
| in_word | input | 32 | Four characters, lane 0 earliest |
| hit | output | 1 | Pattern found in the word accepted one clock earlier |
| hit_offset | output | 2 | Lowest start position that hit (0 when no hit) |

## Verification
Each word's verdict appears on hit and hit_offset exactly one clock after the edge that accepts it. Idle and reset cycles give a zero result with the same one-clock lag. The bench drives inputs on the falling edge and compares both outputs on the next falling edge against a queue-based model, which keeps a short history of characters since the packet start. Two copies of the block run the same stimulus: one with a string that cannot overlap itself, and one with a repeated character, which makes several offsets hit in the same cycle. Directed straddle, reset, packet-start and idle-gap cases come before a long pseudo-random stream over a four-letter alphabet.

// File: rtl/qlm_pkg.sv
package qlm_pkg;

  // Index of the lowest set bit among the first n bits of v (0 if none).
  function automatic int unsigned lowest_set(input logic [31:0] v, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/qlm_window.sv
module qlm_window #(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned RET    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic                          in_sop,
  input  logic [LANES*CHAR_W-1:0]       in_word,
  output logic [(RET+LANES)*CHAR_W-1:0] win,
  output logic                          ret_ok
);
  logic [RET*CHAR_W-1:0] ret_q;
  logic                  held_ok;

  // Keep the newest RET characters of every accepted word.
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_q   <= '0;
      held_ok <= 1'b0;
    end else if (in_valid) begin
      ret_q   <= in_word[LANES*CHAR_W-1 -: RET*CHAR_W];
      held_ok <= 1'b1;
    end
  end

  // Earliest characters at the low positions of the view.
  assign win    = {in_word, ret_q};
  assign ret_ok = held_ok && !in_sop;

  // R7: idle cycles leave the held characters untouched
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(ret_q));

endmodule

// File: rtl/qlm_column.sv
module qlm_column #(
  parameter int unsigned       CHAR_W = 8,
  parameter int unsigned       LANES  = 4,
  parameter logic [CHAR_W-1:0] CHR    = '0
) (
  input  logic [LANES*CHAR_W-1:0] slice,
  output logic [LANES-1:0]        eq
);
  // One stored character, one comparator per start offset.
  localparam logic [CHAR_W-1:0] STORED = CHR;

  for (genvar k = 0; k < LANES; k++) begin : g_cmp
    assign eq[k] = (slice[k*CHAR_W +: CHAR_W] == STORED);
  end

endmodule

// File: rtl/qlm_resolve.sv
module qlm_resolve #(
  parameter int unsigned LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [LANES-1:0]           ofs_ok,
  output logic                       hit,
  output logic [$clog2(LANES)-1:0]   hit_offset
);
  import qlm_pkg::*;
  localparam int unsigned OFS_W = $clog2(LANES);

  logic any_ok;
  assign any_ok = in_valid && (|ofs_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit        <= 1'b0;
      hit_offset <= '0;
    end else begin
      hit        <= any_ok;
      hit_offset <= any_ok ? OFS_W'(lowest_set(32'(ofs_ok), LANES)) : '0;
    end
  end

  // R1: a hit only follows an accepted word
  assert_hit_after_valid_R1: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(in_valid));

  // R8: offset 0 wins whenever it qualifies
  assert_lowest_first_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ofs_ok[0]) |=> (hit && hit_offset == '0));

endmodule

// File: rtl/quad_lane_matcher.sv
module quad_lane_matcher #(
  parameter int unsigned               CHAR_W  = 8,
  parameter int unsigned               LANES   = 4,
  parameter int unsigned               PAT_LEN = 4,
  parameter logic [PAT_LEN*CHAR_W-1:0] PATTERN = 32'h4443_4241
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_sop,
  input  logic [LANES*CHAR_W-1:0]  in_word,
  output logic                     hit,
  output logic [$clog2(LANES)-1:0] hit_offset
);
  localparam int unsigned RET = PAT_LEN - 1;
  localparam int unsigned WIN = RET + LANES;

  logic [WIN*CHAR_W-1:0] win;
  logic                  ret_ok;
  logic [LANES-1:0]      col_eq [PAT_LEN];
  logic [LANES-1:0]      ofs_ok;

  qlm_window #(.CHAR_W(CHAR_W), .LANES(LANES), .RET(RET)) u_window (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_word(in_word), .win(win), .ret_ok(ret_ok)
  );

  // Column c compares its character with view positions c .. c+LANES-1.
  for (genvar c = 0; c < PAT_LEN; c++) begin : g_col
    qlm_column #(
      .CHAR_W(CHAR_W), .LANES(LANES),
      .CHR(PATTERN[c*CHAR_W +: CHAR_W])
    ) u_col (
      .slice(win[c*CHAR_W +: LANES*CHAR_W]),
      .eq(col_eq[c])
    );
  end

  // Offsets that start in held characters need them to be valid.
  always_comb begin
    for (int k = 0; k < int'(LANES); k++) begin
      ofs_ok[k] = (k >= int'(RET)) || ret_ok;
      for (int c = 0; c < int'(PAT_LEN); c++) begin
        ofs_ok[k] = ofs_ok[k] && col_eq[c][k];
      end
    end
  end

  qlm_resolve #(.LANES(LANES)) u_resolve (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ofs_ok(ofs_ok),
    .hit(hit), .hit_offset(hit_offset)
  );

  // R6: a packet-start word never hits at an offset that uses held bytes
  assert_sop_masks_held_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |=> (!hit || hit_offset >= RET));

  // R9: outputs are clear after a reset edge
  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> (!hit && hit_offset == '0));

  // R9: no offset is shown without a hit
  assert_idle_offset_R9: assert property (@(posedge clk) disable iff (rst)
    !hit |-> hit_offset == '0);

endmodule

// File: tb/quad_lane_matcher_test.sv
module quad_lane_matcher_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [31:0] in_word = '0;
  logic        hit_a, hit_b;
  logic [1:0]  ofs_a, ofs_b;

  localparam logic [31:0] PAT_A = 32'h4443_4241; // "ABCD"
  localparam logic [31:0] PAT_B = 32'h4141_4141; // "AAAA"

  always #4 clk = ~clk; // 125 MHz

  quad_lane_matcher uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_word(in_word), .hit(hit_a), .hit_offset(ofs_a)
  );

  quad_lane_matcher #(.PATTERN(PAT_B)) uut_rep (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_word(in_word), .hit(hit_b), .hit_offset(ofs_b)
  );

  byte unsigned hist_q[$];
  logic         exp_hit_a = 1'b0, exp_hit_b = 1'b0;
  logic [1:0]   exp_ofs_a = '0, exp_ofs_b = '0;
  string        tag_now = "R9 reset";
  int           n_tests = 0;
  int           n_fail = 0;

  function automatic logic [31:0] wd(input string s);
    return {s[3], s[2], s[1], s[0]};
  endfunction

  task automatic model_eval(input logic [31:0] pat, output logic h, output logic [1:0] o);
    int n;
    h = 1'b0;
    o = '0;
    n = hist_q.size();
    for (int k = 3; k >= 0; k--) begin
      int  s;
      bit  ok;
      s = n - 7 + k;
      if (s >= 0) begin
        ok = 1'b1;
        for (int c = 0; c < 4; c++)
          if (hist_q[s + c] != pat[8*c +: 8]) ok = 1'b0;
        if (ok) begin
          h = 1'b1;
          o = 2'(k);
        end
      end
    end
  endtask

  task automatic check_outputs();
    n_tests++;
    if (hit_a !== exp_hit_a || ofs_a !== exp_ofs_a) begin
      n_fail++;
      $display("FAIL %s (ABCD): hit=%0b offset=%0d expected hit=%0b offset=%0d",
               tag_now, hit_a, ofs_a, exp_hit_a, exp_ofs_a);
    end
    n_tests++;
    if (hit_b !== exp_hit_b || ofs_b !== exp_ofs_b) begin
      n_fail++;
      $display("FAIL %s (AAAA): hit=%0b offset=%0d expected hit=%0b offset=%0d",
               tag_now, hit_b, ofs_b, exp_hit_b, exp_ofs_b);
    end
  endtask

  // One clock: check the result of the previous stimulus, then drive the next.
  task automatic step(input logic r, input logic v, input logic sop,
                      input logic [31:0] w, input string tag);
    @(negedge clk);
    check_outputs();
    if (r) begin
      hist_q.delete();
      exp_hit_a = 1'b0; exp_ofs_a = '0;
      exp_hit_b = 1'b0; exp_ofs_b = '0;
    end else if (v) begin
      if (sop) hist_q.delete();
      for (int i = 0; i < 4; i++) hist_q.push_back(w[8*i +: 8]);
      while (hist_q.size() > 7) void'(hist_q.pop_front());
      model_eval(PAT_A, exp_hit_a, exp_ofs_a);
      model_eval(PAT_B, exp_hit_b, exp_ofs_b);
    end else begin
      exp_hit_a = 1'b0; exp_ofs_a = '0;
      exp_hit_b = 1'b0; exp_ofs_b = '0;
    end
    tag_now  = tag;
    rst      = r;
    in_valid = v;
    in_sop   = sop;
    in_word  = w;
  endtask

  task automatic send(input string s, input string tag);
    step(1'b0, 1'b1, 1'b0, wd(s), tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    step(1'b1, 1'b0, 1'b0, 32'h0, "R9 reset held");
    step(1'b1, 1'b0, 1'b0, 32'h0, "R9 reset held");
    send("zABC", "R1 lead-in word");
    step(1'b1, 1'b0, 1'b0, 32'h0, "R9 reset between words");
    send("Dzzz", "R5 held bytes invalid after reset");
    send("ABCD", "R2 aligned match at offset 3");
    idle("R1 idle cycle gives no hit");
    send("zCAB", "R4 example lead word");
    send("CDFE", "R4 example match at offset 1");
    send("zzzA", "R3 lead");
    send("BCDz", "R3 straddle match at offset 2");
    send("zzAB", "R3 lead");
    send("CDzz", "R3 straddle match at offset 1");
    send("zABC", "R3 lead");
    send("Dzzz", "R3 straddle match at offset 0");
    send("zABC", "R6 lead");
    step(1'b0, 1'b1, 1'b1, wd("Dzzz"), "R6 packet start hides held bytes");
    send("zzzz", "R6 filler");
    send("zzAB", "R7 lead");
    idle("R7 idle gap");
    idle("R7 idle gap");
    send("CDzz", "R7 match across idle gap at offset 1");
    step(1'b0, 1'b1, 1'b1, wd("AAAA"), "R6 packet start repeated pattern at offset 3");
    send("AAAA", "R8 several offsets, lowest reported");
    send("zzAA", "R8 lead");
    send("AAzz", "R8 single straddle at offset 1");
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      for (int b = 0; b < 4; b++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        w[8*b +: 8] = 8'h41 + 8'(lfsr[1:0]);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0)
        idle("R7 random idle");
      else
        step(1'b0, 1'b1, (lfsr[7:4] == 4'h0), w, "R1 random stream");
    end
    idle("R1 flush");
    idle("R1 flush");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule